// File: doc/BRIEF.md
# SPI Word-Stream Memory Reader

This block is an SPI slave that lets an external master read an on-chip memory organised in 32-bit words. The master pulls the select line low and shifts in two bytes: a command byte, then a byte holding the starting word address. The block then returns whole words on MISO, most significant bit first. It moves to the next word address after each word, so a single select-low period can read any number of consecutive words. Raising select ends the transfer at once.

SCLK idles low. The block samples MOSI on SCLK falling edges and changes MISO on SCLK rising edges, so the master samples MISO on the falling edge. All three SPI inputs pass through two-flop synchronisers into the system clock, and edges are detected there. The block fetches each word through a one-cycle synchronous read port. It requests the next word one byte period before that word's first bit is due, which hides the memory latency. Addresses at or above the memory's word count return zeros.

Top module: `spi_word_reader`

## Requirements
- R1: A transfer begins with a command byte and then an address byte. Both are shifted in MSB first, and each bit is taken on an SCLK falling edge. A command byte of 0x7F selects a word read.
- R2: The word address is bits 6..0 of the address byte. Bit 7 has no effect on which word is returned.
- R3: Each word goes out on MISO from bit 31 down to bit 0, one bit per SCLK rising edge. Bit 31 of the first word appears on the first rising edge after the eighth falling edge of the address byte.
- R4: After each 32-bit word the word address increments by one, so one transfer reads consecutive words. The 7-bit address wraps from 127 to 0.
- R5: A word whose address is at or above MEM_WORDS (default 100) goes out as 32 zero bits, whatever the memory port returns.
- R6: If the command byte is not 0x7F, MISO stays 0 until select rises, and no memory read is issued.
- R7: While select is high, MISO is 0. Raising select mid-word aborts the transfer, and the next transfer starts from a fresh state.
- R8: Each memory read is a one-cycle mem_re pulse. Reading N words in one transfer issues N+1 reads: one when the address byte completes, and one more when bit 7 of each word (the 25th bit) is driven, which prefetches the following address.
- R9: After reset, MISO and mem_re are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock from the master, idles low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low select |
| spi_miso | output | 1 | Serial data to the master |
| mem_re | output | 1 | One-cycle read request to the memory |
| mem_addr | output | ADDR_W | Word address of the read request |
| mem_rdata | input | WORD_W | Read data, valid the cycle after mem_re |

## Verification
The bench uses the default parameters: 32-bit words, 7-bit addresses and a MEM_WORDS of 100. With MEM_WORDS below the 128 addressable words, the bench can walk a transfer across the 99→100 boundary, where real data turns into zeros. It can also start at address 127 and see the wrap to address 0, where real data returns. The bench's memory model deliberately returns non-zero data for addresses that do not exist. A block that failed to substitute zeros would therefore show up at MISO.

// File: rtl/spi_word_reader.sv
module spi_word_reader #(
  parameter int          WORD_W    = 32,
  parameter int          ADDR_W    = 7,
  parameter int          MEM_WORDS = 100,
  parameter logic [7:0]  READ_CMD  = 8'h7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  output logic              spi_miso,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int BW          = $clog2(WORD_W);
  localparam int PREFETCH_AT = WORD_W - 8;

  typedef enum logic [1:0] {ST_CMD, ST_ADDR, ST_STREAM, ST_REJECT} st_t;

  logic [2:0]        sck_q;
  logic [1:0]        mosi_q, cs_q;
  st_t               st;
  logic [6:0]        rx_sh;
  logic [2:0]        rx_cnt;
  logic [WORD_W-1:0] tx_sh, nxt_word;
  logic [BW-1:0]     tx_cnt;
  logic [ADDR_W-1:0] word_addr, mem_addr_q;
  logic              miso_q, re_q, req_ok, load_pend;

  wire       rise    = sck_q[1] & ~sck_q[2];
  wire       fall    = ~sck_q[1] & sck_q[2];
  wire       cs_s    = cs_q[1];
  wire [7:0] rx_byte = {rx_sh, mosi_q[1]};

  wire req_now = !cs_s &&
                 ((st == ST_ADDR && fall && rx_cnt == 3'd7) ||
                  (st == ST_STREAM && rise && tx_cnt == BW'(PREFETCH_AT)));
  wire [ADDR_W-1:0] req_addr = (st == ST_ADDR) ? rx_byte[ADDR_W-1:0]
                                               : word_addr + 1'b1;

  assign spi_miso = miso_q;
  assign mem_re   = re_q;
  assign mem_addr = mem_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q      <= '0;
      mosi_q     <= '0;
      cs_q       <= '1;
      st         <= ST_CMD;
      rx_sh      <= '0;
      rx_cnt     <= '0;
      tx_sh      <= '0;
      tx_cnt     <= '0;
      nxt_word   <= '0;
      word_addr  <= '0;
      mem_addr_q <= '0;
      miso_q     <= 1'b0;
      re_q       <= 1'b0;
      req_ok     <= 1'b0;
      load_pend  <= 1'b0;
    end else begin
      sck_q     <= {sck_q[1:0], spi_sck};
      mosi_q    <= {mosi_q[0], spi_mosi};
      cs_q      <= {cs_q[0], spi_cs_n};
      re_q      <= 1'b0;
      load_pend <= re_q;
      if (load_pend) nxt_word <= req_ok ? mem_rdata : '0;

      if (req_now) begin
        re_q       <= 1'b1;
        mem_addr_q <= req_addr;
        word_addr  <= req_addr;
        req_ok     <= ({1'b0, req_addr} < (ADDR_W+1)'(MEM_WORDS));
      end

      if (cs_s) begin
        st     <= ST_CMD;
        rx_cnt <= '0;
        tx_cnt <= '0;
        miso_q <= 1'b0;
      end else begin
        case (st)
          ST_CMD: if (fall) begin
            rx_sh  <= rx_byte[6:0];
            rx_cnt <= rx_cnt + 1'b1;
            if (rx_cnt == 3'd7) st <= (rx_byte == READ_CMD) ? ST_ADDR : ST_REJECT;
          end
          ST_ADDR: if (fall) begin
            rx_sh  <= rx_byte[6:0];
            rx_cnt <= rx_cnt + 1'b1;
            if (rx_cnt == 3'd7) begin
              st     <= ST_STREAM;
              tx_cnt <= '0;
            end
          end
          ST_STREAM: if (rise) begin
            if (tx_cnt == '0) begin
              miso_q <= nxt_word[WORD_W-1];
              tx_sh  <= {nxt_word[WORD_W-2:0], 1'b0};
            end else begin
              miso_q <= tx_sh[WORD_W-1];
              tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
            end
            tx_cnt <= tx_cnt + 1'b1;
          end
          default: miso_q <= 1'b0;
        endcase
      end
    end
  end

  assert_quiet_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !spi_miso);
  assert_reject_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REJECT) |-> (!spi_miso && !mem_re));
  assert_miso_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_miso) |-> ($past(rise) || $past(cs_s)));
  assert_read_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re);
  assert_read_in_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> (st == ST_STREAM));
endmodule

// File: tb/tb_spi_word_reader.sv
module tb_spi_word_reader;
  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sck = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
  logic        spi_miso, mem_re;
  logic [6:0]  mem_addr;
  logic [31:0] mem_rdata = '0;
  logic [31:0] rx_words [0:3];
  int          n_chk = 0, n_err = 0, re_count = 0;

  always #5 clk = ~clk;

  spi_word_reader dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] pat(input logic [6:0] a);
    logic [7:0] b;
    b = {1'b0, a};
    return {b, ~b, b ^ 8'h5A, b + 8'd3};
  endfunction

  always @(posedge clk) begin
    if (mem_re) begin
      mem_rdata <= pat(mem_addr);
      re_count  <= re_count + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spi_run(input logic [7:0] cmd, input logic [7:0] ab, input int nread);
    logic [15:0] hdr;
    hdr = {cmd, ab};
    for (int w = 0; w < 4; w++) rx_words[w] = 'x;
    spi_cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      spi_sck = 1'b1; spi_mosi = hdr[15-i];
      repeat (H) @(negedge clk);
      spi_sck = 1'b0;
      repeat (H) @(negedge clk);
    end
    for (int i = 0; i < nread; i++) begin
      spi_sck = 1'b1; spi_mosi = 1'b0;
      repeat (H) @(negedge clk);
      rx_words[i/32][31-(i%32)] = spi_miso;
      spi_sck = 1'b0;
      repeat (H) @(negedge clk);
    end
    spi_cs_n = 1'b1;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9 miso", {31'd0, spi_miso}, 32'd0);
    chk("R9 mem_re", {31'd0, mem_re}, 32'd0);
  endtask

  task automatic t_single;
    int c0 = re_count;
    spi_run(8'h7F, 8'h05, 32);
    chk("R1 R3 word@5", rx_words[0], pat(7'd5));
    chk("R8 reads for 1 word", re_count - c0, 2);
  endtask

  task automatic t_multi;
    int c0 = re_count;
    spi_run(8'h7F, 8'd10, 96);
    chk("R4 word@10", rx_words[0], pat(7'd10));
    chk("R4 word@11", rx_words[1], pat(7'd11));
    chk("R4 word@12", rx_words[2], pat(7'd12));
    chk("R8 reads for 3 words", re_count - c0, 4);
  endtask

  task automatic t_bit7;
    spi_run(8'h7F, 8'h85, 32);
    chk("R2 bit7 ignored", rx_words[0], pat(7'd5));
  endtask

  task automatic t_limit;
    spi_run(8'h7F, 8'd98, 96);
    chk("R5 word@98", rx_words[0], pat(7'd98));
    chk("R5 word@99", rx_words[1], pat(7'd99));
    chk("R5 word@100 zero", rx_words[2], 32'd0);
  endtask

  task automatic t_wrap;
    spi_run(8'h7F, 8'd127, 64);
    chk("R5 word@127 zero", rx_words[0], 32'd0);
    chk("R4 wrap to 0", rx_words[1], pat(7'd0));
  endtask

  task automatic t_reject;
    int c0 = re_count;
    spi_run(8'h7E, 8'h05, 32);
    chk("R6 cmd 7E miso", rx_words[0], 32'd0);
    spi_run(8'h3C, 8'h05, 32);
    chk("R6 cmd 3C miso", rx_words[0], 32'd0);
    chk("R6 no reads", re_count - c0, 0);
  endtask

  task automatic t_abort;
    spi_run(8'h7F, 8'd20, 12);
    chk("R7 partial bits", {20'd0, rx_words[0][31:20]}, {20'd0, pat(7'd20) >> 20});
    chk("R7 miso after deselect", {31'd0, spi_miso}, 32'd0);
    spi_run(8'h7F, 8'd30, 32);
    chk("R7 fresh transfer", rx_words[0], pat(7'd30));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_bit7();
    t_limit();
    t_wrap();
    t_reject();
    t_abort();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule